// File: doc/BRIEF.md
# Interrupt Mask Rise Status Register

This block sits beside the per-function interrupt vector mask storage of a multi-function interface controller. The controller has four physical functions and twenty-eight virtual functions, and each function owns one 32-bit mask word. The block watches every mask word, regardless of which side wrote it. Whenever any bit of a word moves from 0 to 1 while the global rise-report enable is on, the block latches that function's bit in a 32-bit sticky status word.

Local firmware reads the status word through a small synchronous register port. It acknowledges events by writing ones to the bits it has handled. A registered local interrupt line stays high while any status bit is set and not masked by a separate per-function interrupt mask. The mask words are held elsewhere and enter the block as inputs. The block does not send any interrupt messages.

Top module: `mask_rise_stat`

## Requirements
- R1: After reset, every status bit is 0, `irq_o` is 0 and `reg_rdata_o` is 0.
- R2: Status bit i maps to function i. Bits 0..3 are physical functions 0..3 and bits 4..31 are virtual functions 0..27; function i's mask is `fn_mask_i[32*i +: 32]`. When any bit of that word goes from 0 to 1, status bit i becomes 1 at the first clock edge after the change.
- R3: A mask bit going from 1 to 0, or a mask that holds its value, never sets a status bit.
- R4: A rise is reported only if `rise_en_i` is 1 at the edge where the rise is seen. A rise seen while the enable is 0 is dropped and is not reported when the enable returns to 1.
- R5: A write to the status offset clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R6: If a rise and a clear hit the same status bit at the same edge, the bit ends up 1.
- R7: `irq_o` is the OR of (status AND NOT `irq_mask_i`), where an `irq_mask_i` bit of 1 masks that function, registered one edge later. `irq_o` stays high until the contributing bits are cleared or masked.
- R8: The status word sits at word offset `STAT_OFS` (default 0). `reg_rdata_o` shows, one edge after the address is presented, the status held before that edge. Any other offset reads 0, and writes to any other offset change nothing.
- R9: A mask value that is already present when reset is released is taken as the baseline and sets no status bit.
- R10: Rises in several functions at the same edge each set their own status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_mask_i | input | 1024 | Mask words of all functions, function i at bits 32*i+31..32*i |
| rise_en_i | input | 1 | Global enable for reporting mask rises |
| irq_mask_i | input | 32 | Local interrupt mask, 1 blocks that function's status bit |
| reg_addr_i | input | 4 | Register word offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data, ones clear status bits |
| reg_rdata_o | output | 32 | Read data, one cycle after the address |
| irq_o | output | 1 | Local interrupt line |

## Verification
The detector is exercised with several mask patterns:
- A single low bit rising in one physical-function word. This shows that a function maps to the correct status bit.
- The top bit of the last virtual-function word. This exposes slicing errors at the far end of the flattened input.
- Masks falling or holding at nonzero values. These separate edge detection from level detection.
- Several words rising together. This shows whether per-function bits collapse onto one another.
- A rise with the enable low, followed by the enable going high. This tells discarding apart from deferring.
- A rise that lands on the same edge as a clear of the same bit. This shows the priority between set and clear.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int unsigned MRS_PF_DEF     = 4;
  localparam int unsigned MRS_VF_DEF     = 28;
  localparam int unsigned MRS_MASK_W_DEF = 32;
  localparam int unsigned MRS_DATA_W_DEF = 32;
  localparam int unsigned MRS_ADDR_W_DEF = 4;
endpackage

// File: rtl/mrs_rise_detect.sv
// Detects any 0->1 transition of one function's mask word against a held copy.
module mrs_rise_detect #(
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              rise_o
);
  logic [MASK_W-1:0] prev_q;
  logic [MASK_W-1:0] prev_d;
  logic [MASK_W-1:0] up_bits;

  always_comb begin
    prev_d  = mask_i;
    up_bits = mask_i & ~prev_q;
    rise_o  = arm_i & (|up_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/mrs_status_bank.sv
// Sticky status bits: gated set, write-one-to-clear, set has priority.
module mrs_status_bank #(
  parameter int unsigned NUM_FN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [NUM_FN-1:0] set_i,
  input  logic [NUM_FN-1:0] clr_i,
  output logic [NUM_FN-1:0] stat_o
);
  logic [NUM_FN-1:0] stat_q;
  logic [NUM_FN-1:0] stat_d;
  logic [NUM_FN-1:0] set_eff;
  logic              upd;

  always_comb begin
    set_eff = en_i ? set_i : '0;
    stat_d  = (stat_q & ~clr_i) | set_eff;
    upd     = (|set_eff) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/mrs_regport.sv
// Single-register port: decodes the status offset, forms the clear vector, registers read data.
module mrs_regport #(
  parameter int unsigned NUM_FN  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] STAT_OFS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_FN-1:0] stat_i,
  output logic [NUM_FN-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              hit;
  logic [DATA_W-1:0] stat_ext;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    hit      = (addr_i == STAT_OFS);
    stat_ext = '0;
    stat_ext[NUM_FN-1:0] = stat_i;
    clr_o    = (hit && wr_i) ? wdata_i[NUM_FN-1:0] : '0;
    rdata_d  = hit ? stat_ext : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mrs_irq_gate.sv
// Registered local interrupt from unmasked status bits.
module mrs_irq_gate #(
  parameter int unsigned NUM_FN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FN-1:0] stat_i,
  input  logic [NUM_FN-1:0] block_i,
  output logic              irq_o
);
  logic irq_d;
  logic irq_q;

  always_comb irq_d = |(stat_i & ~block_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mask_rise_stat.sv
module mask_rise_stat
  import mrs_pkg::*;
#(
  parameter int unsigned NUM_PF = MRS_PF_DEF,
  parameter int unsigned NUM_VF = MRS_VF_DEF,
  parameter int unsigned MASK_W = MRS_MASK_W_DEF,
  parameter int unsigned DATA_W = MRS_DATA_W_DEF,
  parameter int unsigned ADDR_W = MRS_ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] STAT_OFS = '0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [(NUM_PF+NUM_VF)*MASK_W-1:0]   fn_mask_i,
  input  logic                                rise_en_i,
  input  logic [NUM_PF+NUM_VF-1:0]            irq_mask_i,
  input  logic [ADDR_W-1:0]                   reg_addr_i,
  input  logic                                reg_wr_i,
  input  logic [DATA_W-1:0]                   reg_wdata_i,
  output logic [DATA_W-1:0]                   reg_rdata_o,
  output logic                                irq_o
);
  localparam int unsigned NUM_FN = NUM_PF + NUM_VF;

  logic              armed_q;
  logic              armed_d;
  logic [NUM_FN-1:0] rise_vec;
  logic [NUM_FN-1:0] clr_vec;
  logic [NUM_FN-1:0] stat_q;

  // First edge after reset captures the baseline masks without reporting.
  always_comb armed_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
    mrs_rise_detect #(.MASK_W(MASK_W)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .arm_i (armed_q),
      .mask_i(fn_mask_i[g*MASK_W +: MASK_W]),
      .rise_o(rise_vec[g])
    );
  end

  mrs_status_bank #(.NUM_FN(NUM_FN)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (rise_en_i),
    .set_i (rise_vec),
    .clr_i (clr_vec),
    .stat_o(stat_q)
  );

  mrs_regport #(
    .NUM_FN  (NUM_FN),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS)
  ) u_port (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (reg_addr_i),
    .wr_i   (reg_wr_i),
    .wdata_i(reg_wdata_i),
    .stat_i (stat_q),
    .clr_o  (clr_vec),
    .rdata_o(reg_rdata_o)
  );

  mrs_irq_gate #(.NUM_FN(NUM_FN)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (stat_q),
    .block_i(irq_mask_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/mrs_chk.sv
module mrs_chk #(
  parameter int unsigned NUM_FN = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_OFS = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise_en_i,
  input logic [NUM_FN-1:0] irq_mask_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [NUM_FN-1:0] stat
);
  logic              live_q;
  logic [DATA_W-1:0] stat_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  always_comb begin
    stat_w = '0;
    stat_w[NUM_FN-1:0] = stat;
  end

  // R4
  set_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    ((stat & ~$past(stat)) != '0) |-> $past(rise_en_i));

  // R5
  clr_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (($past(stat) & ~stat) != '0) |-> ($past(reg_wr_i) && ($past(reg_addr_i) == STAT_OFS)));

  // R5
  clr_only_ones_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    ($past(reg_wr_i) || !$past(reg_wr_i)) |->
      (($past(stat) & ~stat & ~$past(reg_wdata_i[NUM_FN-1:0])) == '0));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    irq_o == (|($past(stat) & ~$past(irq_mask_i))));

  // R8
  rd_stat_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    ($past(reg_addr_i) == STAT_OFS) |-> (reg_rdata_o == $past(stat_w)));

  // R8
  rd_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    ($past(reg_addr_i) != STAT_OFS) |-> (reg_rdata_o == '0));
endmodule

bind mask_rise_stat mrs_chk #(
  .NUM_FN  (NUM_FN),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .STAT_OFS(STAT_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rise_en_i  (rise_en_i),
  .irq_mask_i (irq_mask_i),
  .reg_addr_i (reg_addr_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .stat       (stat_q)
);

// File: tb/sim_mask_rise_stat.sv
module sim_mask_rise_stat;
  localparam int CLK_PERIOD = 10;
  localparam int NFN  = 32;
  localparam int MW   = 32;
  localparam logic [3:0] OFS   = 4'h0;
  localparam logic [3:0] OTHER = 4'h7;

  logic            clk;
  logic            rst_n;
  logic [NFN*MW-1:0] fn_mask;
  logic            rise_en;
  logic [NFN-1:0]  irq_mask;
  logic [3:0]      reg_addr;
  logic            reg_wr;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mask_rise_stat u0 (
    .clk(clk), .rst_n(rst_n), .fn_mask_i(fn_mask), .rise_en_i(rise_en),
    .irq_mask_i(irq_mask), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mask(input int fn, input logic [31:0] v);
    fn_mask[fn*MW +: MW] = v;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
    reg_addr = OFS;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    tick();
    reg_wr    = 1'b0;
    reg_wdata = '0;
    reg_addr  = OFS;
  endtask

  task automatic clear_all();
    fn_mask = '0;
    tick();
    wr(OFS, 32'hFFFF_FFFF);
    tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    rd(OFS, d);
    chk("R9 baseline mask sets nothing", d, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    clear_all();
    set_mask(1, 32'h0000_0020);
    tick();
    chk("R7 irq one edge after status", {31'b0, irq}, 32'h0);
    rd(OFS, d);
    chk("R2 PF1 rise sets bit 1", d, 32'h0000_0002);
    chk("R7 irq follows status", {31'b0, irq}, 32'h1);
    set_mask(31, 32'h8000_0000);
    tick();
    rd(OFS, d);
    chk("R2 VF27 top bit sets bit 31", d, 32'h8000_0002);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    clear_all();
    set_mask(2, 32'h0000_00FF);
    tick();
    wr(OFS, 32'hFFFF_FFFF);
    set_mask(2, 32'h0000_000F);
    tick();
    tick();
    tick();
    rd(OFS, d);
    chk("R3 fall and hold set nothing", d, 32'h0);
  endtask

  task automatic t_en_off();
    logic [31:0] d;
    clear_all();
    rise_en = 1'b0;
    set_mask(5, 32'h1);
    tick();
    tick();
    rise_en = 1'b1;
    tick();
    rd(OFS, d);
    chk("R4 rise with enable off dropped", d, 32'h0);
    chk("R4 no irq from dropped rise", {31'b0, irq}, 32'h0);
    set_mask(5, 32'h3);
    tick();
    rd(OFS, d);
    chk("R4 rise with enable on reported", d, 32'h0000_0020);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    clear_all();
    set_mask(0, 32'h1);
    set_mask(9, 32'h0001_0000);
    set_mask(20, 32'h4000_0000);
    tick();
    rd(OFS, d);
    chk("R10 three functions in one edge", d, 32'h0010_0201);
    wr(OFS, 32'h0);
    rd(OFS, d);
    chk("R5 write zero keeps status", d, 32'h0010_0201);
    wr(OFS, 32'h0000_0200);
    rd(OFS, d);
    chk("R5 write one clears only that bit", d, 32'h0010_0001);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    clear_all();
    set_mask(6, 32'h1);
    tick();
    set_mask(6, 32'h3);
    wr(OFS, 32'h0000_0040);
    rd(OFS, d);
    chk("R6 set wins over clear", d, 32'h0000_0040);
    wr(OFS, 32'h0000_0040);
    rd(OFS, d);
    chk("R5 clear without rise", d, 32'h0);
  endtask

  task automatic t_irq();
    clear_all();
    chk("R7 irq low when empty", {31'b0, irq}, 32'h0);
    irq_mask = 32'h0000_0008;
    set_mask(3, 32'h1);
    tick();
    tick();
    chk("R7 masked bit gives no irq", {31'b0, irq}, 32'h0);
    irq_mask = '0;
    tick();
    chk("R7 unmask raises irq", {31'b0, irq}, 32'h1);
    irq_mask = 32'h0000_0008;
    tick();
    chk("R7 mask lowers irq", {31'b0, irq}, 32'h0);
    irq_mask = '0;
    tick();
    wr(OFS, 32'h0000_0008);
    chk("R7 irq held until clear registers", {31'b0, irq}, 32'h1);
    tick();
    chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    clear_all();
    set_mask(12, 32'h1);
    tick();
    wr(OTHER, 32'hFFFF_FFFF);
    rd(OFS, d);
    chk("R8 write to other offset ignored", d, 32'h0000_1000);
    rd(OTHER, d);
    chk("R8 other offset reads zero", d, 32'h0);
  endtask

  initial begin
    rst_n     = 1'b0;
    fn_mask   = '0;
    fn_mask[2*MW +: MW] = 32'h0000_00FF;
    rise_en   = 1'b1;
    irq_mask  = '0;
    reg_addr  = OFS;
    reg_wr    = 1'b0;
    reg_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    tick();
    t_reset();
    t_single();
    t_fall();
    t_en_off();
    t_w1c();
    t_collide();
    t_irq();
    t_addr();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule